// File: doc/BRIEF.md
# Scoreboard-Gated Issue Queue

This block is a small issue queue for a single class of execution unit. Decode pushes an instruction into the queue as an opcode, two source register numbers and one destination register number. Each instruction waits in a slot until both of its sources are marked valid in a per-register validity table and the execution unit reports that it can accept work. The queue then sends one instruction to the unit. It does not carry operand values. Readiness is judged at the moment of issue, by reading the validity table.

When several slots are ready in one cycle, the instruction that entered the queue first wins. Issuing an instruction marks its destination invalid, so any later reader of that register is held back. The block tracks the unit's fixed execution latency internally. When that latency has passed, it raises a completion strobe carrying the destination number and marks the register valid again. Any register's validity can be read through a query port.

The queue depth and the latency are parameters. An ALU queue uses a depth of 2 and a latency of 1. A load/store queue uses a depth of 3 and a latency of 2, which is the default.

Top module: `sbrs_station`

## Requirements
- R1: After reset the queue is empty (`dsp_full` = 0, `iss_valid` = 0, `cpl_valid` = 0), and `qry_valid` reads 1 for every one of the 2^REG_W registers.
- R2: A push (`dsp_valid` = 1) is taken only in a cycle where `dsp_full` is 0. `dsp_full` is 1 exactly when all ENTRIES slots hold an instruction at the start of the cycle. A push offered while `dsp_full` is 1 is dropped and never issues, even if an issue frees a slot in that same cycle.
- R3: An instruction is presented on the issue port only when the validity table marks both its source registers valid.
- R4: `iss_valid` is 0 whenever `unit_free` is 0, and no instruction leaves the queue in such a cycle.
- R5: In the cycle after an issue, `qry_valid` for the issued destination reads 0.
- R6: `cpl_valid` is 1 with `cpl_rd` equal to the destination exactly EXEC_LAT cycles after the issue cycle. The register reads valid from the following cycle on, and a waiting reader of it can issue in that cycle.
- R7: When several slots are ready, the instruction pushed earliest issues, whatever slot it occupies. A younger ready instruction may issue ahead of an older one that is not ready.
- R8: If a completion and an issue name the same register in the same cycle, the register ends that cycle invalid.
- R9: At most one instruction issues per cycle. The issued instruction leaves the queue and is never issued again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dsp_valid | input | 1 | Push request from decode |
| dsp_op | input | OP_W | Opcode of the pushed instruction |
| dsp_rd | input | REG_W | Destination register number |
| dsp_rs1 | input | REG_W | First source register number |
| dsp_rs2 | input | REG_W | Second source register number |
| dsp_full | output | 1 | All slots occupied; decode must stall |
| unit_free | input | 1 | Execution unit can accept an instruction this cycle |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_op | output | OP_W | Opcode of the issued instruction |
| iss_rd | output | REG_W | Destination of the issued instruction |
| iss_rs1 | output | REG_W | First source of the issued instruction |
| iss_rs2 | output | REG_W | Second source of the issued instruction |
| cpl_valid | output | 1 | Completion strobe, EXEC_LAT cycles after issue |
| cpl_rd | output | REG_W | Register completed |
| qry_reg | input | REG_W | Register number to look up |
| qry_valid | output | 1 | Validity of `qry_reg` |

## Verification
The issue port is combinational from the queue state, so it is checked in the same cycle the inputs are applied. A push becomes visible to selection one cycle after it is offered. The cleared destination shows on the query port one cycle after the issue cycle. With the default latency of 2, the completion strobe appears two cycles after the issue cycle, and validity and the dependent issue follow one cycle later. The bench advances one clock at a time. It sets inputs and samples outputs 2 ns after each rising edge, then counts those cycles explicitly for every check, including the case where a completion and an issue collide on the same register.

// File: rtl/sbrs_pkg.sv
package sbrs_pkg;

   localparam int unsigned SBRS_DEF_REG_W   = 4;
   localparam int unsigned SBRS_DEF_OP_W    = 6;
   localparam int unsigned SBRS_DEF_ENTRIES = 3;
   localparam int unsigned SBRS_DEF_LAT     = 2;

   // width of an age rank able to hold 0 .. n-1
   function automatic int unsigned sbrs_rank_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/sbrs_scoreboard.sv
module sbrs_scoreboard #(
   parameter int unsigned REG_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    set_en,
   input  logic [REG_W-1:0]        set_reg,
   input  logic                    clr_en,
   input  logic [REG_W-1:0]        clr_reg,
   output logic [(1<<REG_W)-1:0]   vld_o
);
   localparam int unsigned NUM_REGS = 1 << REG_W;

   if (REG_W < 1 || REG_W > 8) begin : g_bad_reg_w
      $error("sbrs_scoreboard: REG_W out of range");
   end

   logic [NUM_REGS-1:0] vld_q;
   logic [NUM_REGS-1:0] set_hot;
   logic [NUM_REGS-1:0] clr_hot;

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      assign set_hot[r] = set_en && (set_reg == REG_W'(r));
      assign clr_hot[r] = clr_en && (clr_reg == REG_W'(r));
   end

   // completion set first, issue clear applied on top of it
   always_ff @(posedge clk) begin
      if (!rst_n) vld_q <= '1;
      else        vld_q <= (vld_q | set_hot) & ~clr_hot;
   end

   assign vld_o = vld_q;

   p_clear_on_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> !vld_o[$past(clr_reg)]);

   p_set_on_cpl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !(clr_en && clr_reg == set_reg)) |=> vld_o[$past(set_reg)]);

   p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && clr_en && clr_reg == set_reg) |=> !vld_o[$past(set_reg)]);

endmodule

// File: rtl/sbrs_age_pick.sv
module sbrs_age_pick #(
   parameter int unsigned ENTRIES = 3,
   parameter int unsigned RANK_W  = 2
) (
   input  logic [ENTRIES-1:0]        req,
   input  logic [ENTRIES*RANK_W-1:0] rank_flat,
   output logic [ENTRIES-1:0]        grant
);
   if (ENTRIES == 1) begin : g_single
      assign grant = req;
   end else begin : g_multi
      for (genvar i = 0; i < ENTRIES; i++) begin : g_cand
         logic beaten;
         always_comb begin
            beaten = 1'b0;
            for (int j = 0; j < ENTRIES; j++) begin
               if (j != i && req[j] &&
                   rank_flat[j*RANK_W +: RANK_W] < rank_flat[i*RANK_W +: RANK_W])
                  beaten = 1'b1;
            end
         end
         assign grant[i] = req[i] && !beaten;
      end
   end

endmodule

// File: rtl/sbrs_lat_pipe.sv
module sbrs_lat_pipe #(
   parameter int unsigned EXEC_LAT = 2,
   parameter int unsigned REG_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [REG_W-1:0] in_reg,
   output logic             out_vld,
   output logic [REG_W-1:0] out_reg
);
   if (EXEC_LAT < 1 || EXEC_LAT > 64) begin : g_bad_lat
      $error("sbrs_lat_pipe: EXEC_LAT out of range");
   end

   if (EXEC_LAT == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_vld <= 1'b0;
            out_reg <= '0;
         end else begin
            out_vld <= in_vld;
            out_reg <= in_reg;
         end
      end
   end else begin : g_chain
      logic [EXEC_LAT-1:0] vld_q;
      logic [REG_W-1:0]    reg_q [EXEC_LAT];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= '0;
            for (int k = 0; k < EXEC_LAT; k++) reg_q[k] <= '0;
         end else begin
            vld_q    <= {vld_q[EXEC_LAT-2:0], in_vld};
            reg_q[0] <= in_reg;
            for (int k = 1; k < EXEC_LAT; k++) reg_q[k] <= reg_q[k-1];
         end
      end
      assign out_vld = vld_q[EXEC_LAT-1];
      assign out_reg = reg_q[EXEC_LAT-1];
   end

endmodule

// File: rtl/sbrs_station.sv
module sbrs_station
   import sbrs_pkg::*;
#(
   parameter int unsigned ENTRIES  = SBRS_DEF_ENTRIES,
   parameter int unsigned EXEC_LAT = SBRS_DEF_LAT,
   parameter int unsigned REG_W    = SBRS_DEF_REG_W,
   parameter int unsigned OP_W     = SBRS_DEF_OP_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dsp_valid,
   input  logic [OP_W-1:0]  dsp_op,
   input  logic [REG_W-1:0] dsp_rd,
   input  logic [REG_W-1:0] dsp_rs1,
   input  logic [REG_W-1:0] dsp_rs2,
   output logic             dsp_full,
   input  logic             unit_free,
   output logic             iss_valid,
   output logic [OP_W-1:0]  iss_op,
   output logic [REG_W-1:0] iss_rd,
   output logic [REG_W-1:0] iss_rs1,
   output logic [REG_W-1:0] iss_rs2,
   output logic             cpl_valid,
   output logic [REG_W-1:0] cpl_rd,
   input  logic [REG_W-1:0] qry_reg,
   output logic             qry_valid
);
   localparam int unsigned NUM_REGS = 1 << REG_W;
   localparam int unsigned RANK_W   = sbrs_rank_w(ENTRIES);

   if (ENTRIES < 1 || ENTRIES > 32) begin : g_bad_entries
      $error("sbrs_station: ENTRIES out of range");
   end
   if (OP_W < 1) begin : g_bad_op_w
      $error("sbrs_station: OP_W must be positive");
   end

   // slot storage
   logic [ENTRIES-1:0] busy_q;
   logic [OP_W-1:0]    op_q  [ENTRIES];
   logic [REG_W-1:0]   rd_q  [ENTRIES];
   logic [REG_W-1:0]   rs1_q [ENTRIES];
   logic [REG_W-1:0]   rs2_q [ENTRIES];
   logic [RANK_W-1:0]  rank_q[ENTRIES];

   logic [NUM_REGS-1:0]       sb_vld;
   logic [ENTRIES-1:0]        ready;
   logic [ENTRIES-1:0]        grant;
   logic [ENTRIES-1:0]        alloc;
   logic [ENTRIES*RANK_W-1:0] rank_flat;
   logic [RANK_W-1:0]         iss_rank;
   logic [RANK_W:0]           occ;
   logic [RANK_W:0]           occ_after;
   logic [RANK_W-1:0]         rank_new;
   logic                      dsp_take;
   logic                      pipe_vld;
   logic [REG_W-1:0]          pipe_reg;

   // issue-bound readiness: read the validity table now
   for (genvar i = 0; i < ENTRIES; i++) begin : g_ready
      assign ready[i] = busy_q[i] && sb_vld[rs1_q[i]] && sb_vld[rs2_q[i]];
      assign rank_flat[i*RANK_W +: RANK_W] = rank_q[i];
   end

   sbrs_age_pick #(
      .ENTRIES (ENTRIES),
      .RANK_W  (RANK_W)
   ) u_pick (
      .req       (ready),
      .rank_flat (rank_flat),
      .grant     (grant)
   );

   assign iss_valid = unit_free && (|grant);

   always_comb begin
      iss_op   = '0;
      iss_rd   = '0;
      iss_rs1  = '0;
      iss_rs2  = '0;
      iss_rank = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (grant[i]) begin
            iss_op   = iss_op   | op_q[i];
            iss_rd   = iss_rd   | rd_q[i];
            iss_rs1  = iss_rs1  | rs1_q[i];
            iss_rs2  = iss_rs2  | rs2_q[i];
            iss_rank = iss_rank | rank_q[i];
         end
      end
   end

   // push side: lowest free slot, rank = occupants staying this cycle
   assign dsp_full = &busy_q;
   assign dsp_take = dsp_valid && !dsp_full;

   always_comb begin
      alloc = '0;
      occ   = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (busy_q[i]) occ = occ + 1'b1;
         if (!busy_q[i] && alloc == '0) alloc[i] = 1'b1;
      end
      occ_after = occ - (RANK_W+1)'(iss_valid);
      rank_new  = occ_after[RANK_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            op_q[i]   <= '0;
            rd_q[i]   <= '0;
            rs1_q[i]  <= '0;
            rs2_q[i]  <= '0;
            rank_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (iss_valid && grant[i]) begin
               busy_q[i] <= 1'b0;
            end else if (busy_q[i] && iss_valid && rank_q[i] > iss_rank) begin
               rank_q[i] <= rank_q[i] - 1'b1;
            end
            if (dsp_take && alloc[i]) begin
               busy_q[i] <= 1'b1;
               op_q[i]   <= dsp_op;
               rd_q[i]   <= dsp_rd;
               rs1_q[i]  <= dsp_rs1;
               rs2_q[i]  <= dsp_rs2;
               rank_q[i] <= rank_new;
            end
         end
      end
   end

   // fixed-latency completion tracking
   sbrs_lat_pipe #(
      .EXEC_LAT (EXEC_LAT),
      .REG_W    (REG_W)
   ) u_lat (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (iss_valid),
      .in_reg  (iss_rd),
      .out_vld (pipe_vld),
      .out_reg (pipe_reg)
   );

   assign cpl_valid = pipe_vld;
   assign cpl_rd    = pipe_reg;

   sbrs_scoreboard #(
      .REG_W (REG_W)
   ) u_sb (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (pipe_vld),
      .set_reg (pipe_reg),
      .clr_en  (iss_valid),
      .clr_reg (iss_rd),
      .vld_o   (sb_vld)
   );

   assign qry_valid = sb_vld[qry_reg];

   p_sources_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> (sb_vld[iss_rs1] && sb_vld[iss_rs2]));

   p_full_drops_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_full && !iss_valid) |=> (busy_q == $past(busy_q)));

   p_unit_busy_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!unit_free && !dsp_take) |=> (busy_q == $past(busy_q)));

   p_single_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   p_ready_gets_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|ready) |-> (|grant));

endmodule

// File: tb/sbrs_station_tb.sv
module sbrs_station_tb;
   localparam int unsigned ENTRIES  = 3;
   localparam int unsigned EXEC_LAT = 2;
   localparam int unsigned REG_W    = 4;
   localparam int unsigned OP_W     = 6;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             dsp_valid;
   logic [OP_W-1:0]  dsp_op;
   logic [REG_W-1:0] dsp_rd, dsp_rs1, dsp_rs2;
   logic             dsp_full;
   logic             unit_free;
   logic             iss_valid;
   logic [OP_W-1:0]  iss_op;
   logic [REG_W-1:0] iss_rd, iss_rs1, iss_rs2;
   logic             cpl_valid;
   logic [REG_W-1:0] cpl_rd;
   logic [REG_W-1:0] qry_reg;
   logic             qry_valid;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   sbrs_station #(
      .ENTRIES (ENTRIES), .EXEC_LAT (EXEC_LAT), .REG_W (REG_W), .OP_W (OP_W)
   ) u_dut (
      .clk (clk), .rst_n (rst_n),
      .dsp_valid (dsp_valid), .dsp_op (dsp_op), .dsp_rd (dsp_rd),
      .dsp_rs1 (dsp_rs1), .dsp_rs2 (dsp_rs2), .dsp_full (dsp_full),
      .unit_free (unit_free),
      .iss_valid (iss_valid), .iss_op (iss_op), .iss_rd (iss_rd),
      .iss_rs1 (iss_rs1), .iss_rs2 (iss_rs2),
      .cpl_valid (cpl_valid), .cpl_rd (cpl_rd),
      .qry_reg (qry_reg), .qry_valid (qry_valid)
   );

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic push(input int op, input int rd, input int rs1, input int rs2);
      dsp_valid = 1'b1;
      dsp_op    = OP_W'(op);
      dsp_rd    = REG_W'(rd);
      dsp_rs1   = REG_W'(rs1);
      dsp_rs2   = REG_W'(rs2);
   endtask

   task automatic idle();
      dsp_valid = 1'b0;
   endtask

   task automatic drain();
      idle();
      repeat (EXEC_LAT + 2) step();
   endtask

   task automatic t_reset();
      chk("R1", "dsp_full", dsp_full, 0);
      chk("R1", "iss_valid", iss_valid, 0);
      chk("R1", "cpl_valid", cpl_valid, 0);
      for (int r = 0; r < (1 << REG_W); r++) begin
         qry_reg = REG_W'(r);
         #1;
         chk("R1", $sformatf("qry_valid reg %0d", r), qry_valid, 1);
      end
   endtask

   // fill, refused push, age order across slots
   task automatic t_fill_order();
      unit_free = 1'b0;
      push(1, 1, 2, 3);  step();
      push(2, 4, 5, 6);  step();
      push(3, 7, 8, 9);  step();
      idle(); #1;
      chk("R2", "full after three pushes", dsp_full, 1);
      chk("R4", "no issue while unit busy", iss_valid, 0);
      unit_free = 1'b1;
      push(4, 10, 0, 0); #1;                 // refused: full at cycle start
      chk("R7", "first issue valid", iss_valid, 1);
      chk("R7", "oldest opcode", iss_op, 1);
      chk("R7", "oldest dest", iss_rd, 1);
      step();
      push(12, 11, 0, 0); #1;                // lands in slot 0, youngest
      chk("R2", "full released", dsp_full, 0);
      chk("R7", "second opcode", iss_op, 2);
      step();
      idle(); #1;
      chk("R7", "older slot beats lower index", iss_op, 3);
      step();
      chk("R7", "youngest last", iss_op, 12);
      chk("R9", "youngest issue valid", iss_valid, 1);
      step();
      chk("R2", "refused push never issues", iss_valid, 0);
      chk("R9", "queue empty after drain", dsp_full, 0);
      drain();
   endtask

   // dependency through scoreboard, latency of completion
   task automatic t_dependency();
      unit_free = 1'b1;
      push(5, 3, 1, 2); step();
      push(6, 8, 3, 0); #1;
      chk("R3", "producer issues", iss_op, 5);
      step();
      idle(); qry_reg = 4'd3; #1;
      chk("R5", "dest invalid after issue", qry_valid, 0);
      chk("R3", "reader held", iss_valid, 0);
      chk("R6", "no early completion", cpl_valid, 0);
      step();
      chk("R6", "completion strobe", cpl_valid, 1);
      chk("R6", "completion reg", cpl_rd, 3);
      chk("R3", "reader still held", iss_valid, 0);
      step();
      chk("R6", "dest valid again", qry_valid, 1);
      chk("R6", "reader issues", iss_valid, 1);
      chk("R6", "reader opcode", iss_op, 6);
      step();
      chk("R9", "reader not reissued", iss_valid, 0);
      drain();
   endtask

   task automatic t_unit_gate();
      unit_free = 1'b0;
      push(7, 5, 0, 1); step();
      idle(); qry_reg = 4'd5; #1;
      chk("R4", "held while unit busy", iss_valid, 0);
      step();
      chk("R4", "still held", iss_valid, 0);
      chk("R4", "dest untouched", qry_valid, 1);
      unit_free = 1'b1; #1;
      chk("R4", "issues once free", iss_valid, 1);
      chk("R4", "opcode", iss_op, 7);
      drain();
   endtask

   // younger ready instruction overtakes an older blocked one
   task automatic t_overtake();
      unit_free = 1'b1;
      push(9, 10, 0, 0); step();
      push(10, 12, 10, 0); #1;
      chk("R7", "producer issues", iss_op, 9);
      step();
      push(11, 13, 0, 1); #1;
      chk("R3", "blocked reader waits", iss_valid, 0);
      step();
      idle(); #1;
      chk("R7", "younger ready overtakes", iss_op, 11);
      chk("R7", "younger dest", iss_rd, 13);
      step();
      chk("R7", "older issues when ready", iss_op, 10);
      drain();
   endtask

   // completion and issue hit the same register
   task automatic t_collision();
      unit_free = 1'b1;
      push(13, 14, 0, 0); step();
      idle(); #1;
      chk("R8", "first writer issues", iss_op, 13);
      step();
      push(14, 14, 0, 1); qry_reg = 4'd14; #1;
      chk("R5", "reg 14 invalid", qry_valid, 0);
      step();
      idle(); #1;
      chk("R8", "completion this cycle", cpl_valid, 1);
      chk("R8", "second writer issues same cycle", iss_op, 14);
      step();
      chk("R8", "clear wins over set", qry_valid, 0);
      step();
      chk("R6", "second completion", cpl_valid, 1);
      step();
      chk("R6", "reg 14 valid at last", qry_valid, 1);
      drain();
   endtask

   initial begin
      rst_n = 1'b0; unit_free = 1'b0; qry_reg = '0;
      dsp_valid = 1'b0; dsp_op = '0; dsp_rd = '0; dsp_rs1 = '0; dsp_rs2 = '0;
      repeat (3) step();
      rst_n = 1'b1;
      t_reset();
      t_fill_order();
      t_dependency();
      t_unit_gate();
      t_overtake();
      t_collision();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule